// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block keeps time of day and calendar date as packed BCD counters that advance on a one-pulse-per-second tick from an external prescaler. Beside the counters it holds a second, user-visible copy of every time field. That copy sits in the uppermost sixteen byte addresses of a byte-wide memory space, and software reaches it through a synchronous read/write port. The counters are never addressed directly. Software only sees them through a bulk transfer into the visible copy, which happens once per second, or changes them through a bulk load from the visible copy.

A control byte carries two halt bits. Setting the freeze bit stops the refreshes so that software can read a coherent snapshot while the counters keep running. Setting the set bit also stops refreshes so that software can store new values. Clearing the set bit then loads every time byte, including the century, into the counters. A stop bit in the seconds byte freezes timekeeping altogether, and it can be written without the set bit.

Top module: `rtc_calendar_bank`

## Requirements
- R1: The byte offsets within the top sixteen addresses are: century 1h, control 8h, seconds 9h, minutes Ah, hours Bh, day-of-week Ch, date Dh, month Eh, year Fh. Read data is registered and appears one clock edge after the address. Any other offset, and any address outside the top sixteen, reads 00h.
- R2: Seconds and minutes count 00–59 in BCD, and hours count 00–23 in BCD. Each carries into the next field when it wraps.
- R3: Date counts from 01 up to the length of the current month. February has 29 days when the BCD year is a multiple of four (00 included) and 28 days otherwise. April, June, September and November have 30 days, and all other months have 31.
- R4: Day-of-week counts 01–07 and advances at midnight. Month wraps from 12 to 01 and carries into the year. Year wraps from 99 to 00 and carries into the century.
- R5: On each tick that arrives while neither halt bit is set, all eight time bytes of the visible copy are overwritten together from the counters on the clock edge after the tick. This includes a time byte that software wrote since the last refresh.
- R6: Control bit 6 (freeze) stops refreshes, while the counters keep advancing. After freeze is cleared, the next tick makes the visible copy show the advanced time.
- R7: Control bit 7 (set) stops refreshes, and software writes to time bytes then stay in the visible copy. A control write that clears set while it is 1 loads all eight time bytes into the counters on that edge. Counting continues from the loaded values.
- R8: When a control write that sets a halt bit arrives in the same cycle as a tick, the refresh for that tick still takes place. Refreshes stop only from the following tick.
- R9: Seconds bit 7 is the stop bit. Writing it to 1 stops the counters from advancing on ticks, whatever the halt bits are. Writing it to 0 lets counting resume on the next tick. It reads back in bit 7 of the seconds byte.
- R10: After reset, control reads 00h, the stop bit is 0, and the time reads century 20, year 00, month 01, date 01, day 01, 00:00:00.
- R11: Reserved bits read as 0. Writing FFh reads back as 7Fh for minutes, 3Fh for hours, 07h for day, 3Fh for date, 1Fh for month, C0h for control, and FFh for seconds (stop included), year and century.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write strobe, sampled at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |

## Verification
A tick moves the counters on the edge where it is sampled. The visible copy follows one edge later, and a read returns data on the edge after its address. For this reason the bench holds one idle cycle after every tick before it reads anything. A load caused by clearing the set bit lands on the edge of that control write, so the first check after a load sees the loaded values. Only the following tick shows them incremented. The bench keeps its own binary model of the calendar, with month lengths derived from the year modulo four. It converts that model to BCD at every check, and it sweeps month-end dates for leap and common years, plus two hundred consecutive ticks across midnight.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int OFF_W = 4;
  localparam logic [OFF_W-1:0] OFF_CEN  = 4'h1;
  localparam logic [OFF_W-1:0] OFF_CTRL = 4'h8;
  localparam logic [OFF_W-1:0] OFF_SEC  = 4'h9;
  localparam logic [OFF_W-1:0] OFF_MNT  = 4'hA;
  localparam logic [OFF_W-1:0] OFF_HR   = 4'hB;
  localparam logic [OFF_W-1:0] OFF_DOW  = 4'hC;
  localparam logic [OFF_W-1:0] OFF_DAT  = 4'hD;
  localparam logic [OFF_W-1:0] OFF_MON  = 4'hE;
  localparam logic [OFF_W-1:0] OFF_YR   = 4'hF;

  typedef struct packed {
    logic [7:0] cen;
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] dat;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] mnt;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t RESET_TIME = '{cen: 8'h20, yr: 8'h00, mon: 8'h01, dat: 8'h01,
                                       dow: 8'h01, hr: 8'h00, mnt: 8'h00, sec: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // multiple of four: even tens with units 0/4/8, odd tens with units 2/6
  function automatic logic is_leap(input logic [7:0] y);
    logic u048, u26;
    u048 = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    u26  = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return y[4] ? u26 : u048;
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t time_next(input rtc_time_t c);
    rtc_time_t t;
    t = c;
    if (c.sec < 8'h59) t.sec = bcd_inc(c.sec);
    else begin
      t.sec = 8'h00;
      if (c.mnt < 8'h59) t.mnt = bcd_inc(c.mnt);
      else begin
        t.mnt = 8'h00;
        if (c.hr < 8'h23) t.hr = bcd_inc(c.hr);
        else begin
          t.hr  = 8'h00;
          t.dow = (c.dow >= 8'h07) ? 8'h01 : c.dow + 8'h01;
          if (c.dat < month_days(c.mon, is_leap(c.yr))) t.dat = bcd_inc(c.dat);
          else begin
            t.dat = 8'h01;
            if (c.mon < 8'h12) t.mon = bcd_inc(c.mon);
            else begin
              t.mon = 8'h01;
              if (c.yr < 8'h99) t.yr = bcd_inc(c.yr);
              else begin
                t.yr  = 8'h00;
                t.cen = (c.cen >= 8'h99) ? 8'h00 : bcd_inc(c.cen);
              end
            end
          end
        end
      end
    end
    return t;
  endfunction
endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      stop_i,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  output rtc_time_t cnt_o
);
  rtc_time_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= RESET_TIME;
    else if (load_i)          cnt_q <= load_val_i;
    else if (tick_i && !stop_i) cnt_q <= time_next(cnt_q);
  end

  assign cnt_o = cnt_q;

  p_stop_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !load_i) |=> $stable(cnt_o));
  p_load_takes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_o == $past(load_val_i)));
  p_tick_advances_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !stop_i && !load_i) |=> (cnt_o != $past(cnt_o)));
endmodule

// File: rtl/rtc_user_bank.sv
module rtc_user_bank
  import rtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hit_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             we_i,
  input  logic [7:0]       wdata_i,
  input  rtc_time_t        cnt_i,
  output logic             stop_o,
  output logic             load_o,
  output rtc_time_t        load_val_o,
  output logic [7:0]       rdata_o
);
  rtc_time_t  usr_q;
  logic       frz_q, set_q, stop_q, pend_q;
  logic [7:0] rdata_q, rd_mux;
  logic       wr_hit, ctrl_we;

  assign wr_hit  = we_i && hit_i;
  assign ctrl_we = wr_hit && (off_i == OFF_CTRL);
  assign load_o  = ctrl_we && set_q && !wdata_i[7];
  assign load_val_o = usr_q;
  assign stop_o  = stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frz_q  <= 1'b0;
      set_q  <= 1'b0;
      stop_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      // halt state sampled before this edge: a halt written with the tick does not cancel it
      pend_q <= tick_i && !(frz_q || set_q);
      if (ctrl_we) begin
        set_q <= wdata_i[7];
        frz_q <= wdata_i[6];
      end
      if (wr_hit && off_i == OFF_SEC) stop_q <= wdata_i[7];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) usr_q <= RESET_TIME;
    else if (pend_q) usr_q <= cnt_i;
    else if (wr_hit) begin
      case (off_i)
        OFF_SEC: usr_q.sec <= {1'b0, wdata_i[6:0]};
        OFF_MNT: usr_q.mnt <= {1'b0, wdata_i[6:0]};
        OFF_HR:  usr_q.hr  <= {2'b0, wdata_i[5:0]};
        OFF_DOW: usr_q.dow <= {5'b0, wdata_i[2:0]};
        OFF_DAT: usr_q.dat <= {2'b0, wdata_i[5:0]};
        OFF_MON: usr_q.mon <= {3'b0, wdata_i[4:0]};
        OFF_YR:  usr_q.yr  <= wdata_i;
        OFF_CEN: usr_q.cen <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (off_i)
      OFF_CTRL: rd_mux = {set_q, frz_q, 6'b0};
      OFF_SEC:  rd_mux = {stop_q, usr_q.sec[6:0]};
      OFF_MNT:  rd_mux = usr_q.mnt;
      OFF_HR:   rd_mux = usr_q.hr;
      OFF_DOW:  rd_mux = usr_q.dow;
      OFF_DAT:  rd_mux = usr_q.dat;
      OFF_MON:  rd_mux = usr_q.mon;
      OFF_YR:   rd_mux = usr_q.yr;
      OFF_CEN:  rd_mux = usr_q.cen;
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= 8'h00;
    else         rdata_q <= hit_i ? rd_mux : 8'h00;
  end

  assign rdata_o = rdata_q;

  p_refresh_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> (usr_q == $past(cnt_i)));
  p_halt_freezes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((frz_q || set_q) && !pend_q && !wr_hit) |=> $stable(usr_q));
  p_unmapped_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> (rdata_o == 8'h00));
endmodule

// File: rtl/rtc_calendar_bank.sv
module rtc_calendar_bank
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int HI_W = ADDR_W - OFF_W;

  logic      hit, stop, load;
  rtc_time_t cnt, load_val;

  assign hit = &addr_i[ADDR_W-1 -: HI_W];

  rtc_time_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .stop_i     (stop),
    .load_i     (load),
    .load_val_i (load_val),
    .cnt_o      (cnt)
  );

  rtc_user_bank u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .hit_i      (hit),
    .off_i      (addr_i[OFF_W-1:0]),
    .we_i       (we_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt),
    .stop_o     (stop),
    .load_o     (load),
    .load_val_o (load_val),
    .rdata_o    (rdata_o)
  );
endmodule

// File: tb/rtc_calendar_bank_tb.sv
module rtc_calendar_bank_tb;
  localparam int ADDR_W = 19;
  localparam logic [ADDR_W-5:0] HI = '1;

  logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = 8'h00, rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  int cen, yr, mo, dt, dw, hr, mi, se;
  bit stopped;

  always #4 clk = ~clk;

  rtc_calendar_bank #(.ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata));

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic adv();
    if (stopped) return;
    se++;
    if (se < 60) return;
    se = 0; mi++;
    if (mi < 60) return;
    mi = 0; hr++;
    if (hr < 24) return;
    hr = 0; dw = (dw % 7) + 1; dt++;
    if (dt <= days(mo, yr)) return;
    dt = 1; mo++;
    if (mo <= 12) return;
    mo = 1; yr++;
    if (yr < 100) return;
    yr = 0; cen = (cen + 1) % 100;
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] off, input logic [7:0] d);
    @(negedge clk); addr = {HI, off}; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    @(posedge clk); #1 d = rdata;
  endtask

  task automatic rchk(input string req, input logic [3:0] off, input logic [7:0] exp);
    logic [7:0] d;
    rd({HI, off}, d);
    chk(req, d, exp);
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    rchk(req, 4'h9, {stopped, bcd(se)[6:0]});
    rchk(req, 4'hA, bcd(mi));
    rchk(req, 4'hB, bcd(hr));
    rchk(req, 4'hC, bcd(dw));
    rchk(req, 4'hD, bcd(dt));
    rchk(req, 4'hE, bcd(mo));
    rchk(req, 4'hF, bcd(yr));
    rchk(req, 4'h1, bcd(cen));
  endtask

  task automatic load_model();
    wr(4'h8, 8'h80);
    wr(4'h9, bcd(se)); wr(4'hA, bcd(mi)); wr(4'hB, bcd(hr)); wr(4'hC, bcd(dw));
    wr(4'hD, bcd(dt)); wr(4'hE, bcd(mo)); wr(4'hF, bcd(yr)); wr(4'h1, bcd(cen));
    wr(4'h8, 8'h00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R10 got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] snap, d;
    stopped = 0;
    cen = 20; yr = 0; mo = 1; dt = 1; dw = 1; hr = 0; mi = 0; se = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;

    // R10 reset state, R1 map and unmapped reads
    rchk("R10", 4'h8, 8'h00);
    check_all("R10");
    rchk("R1", 4'h0, 8'h00);
    rchk("R1", 4'h2, 8'h00);
    rchk("R1", 4'h7, 8'h00);
    rd(19'h3FFF9, d); chk("R1", d, 8'h00);

    // R2 run across midnight
    hr = 23; mi = 58; se = 30; dw = 6; load_model();
    check_all("R7");
    for (int i = 0; i < 200; i++) begin
      do_tick(); adv();
      rchk("R2", 4'h9, bcd(se));
      rchk("R2", 4'hA, bcd(mi));
      rchk("R2", 4'hB, bcd(hr));
      rchk("R4", 4'hC, bcd(dw));
    end

    // R3 month ends in common, leap and year-00
    for (int k = 0; k < 3; k++) begin
      for (int m = 1; m <= 12; m++) begin
        cen = 20; yr = (k == 0) ? 23 : (k == 1) ? 24 : 0;
        mo = m; dt = days(m, yr); dw = (m % 7) + 1; hr = 23; mi = 59; se = 59;
        load_model(); do_tick(); adv();
        check_all("R3");
      end
    end
    // R3 day before month end does not wrap
    cen = 20; yr = 23; mo = 2; dt = 27; dw = 2; hr = 23; mi = 59; se = 59;
    load_model(); do_tick(); adv(); check_all("R3");

    // R4 year and century carry, day 7 wraps
    cen = 20; yr = 99; mo = 12; dt = 31; dw = 7; hr = 23; mi = 59; se = 59;
    load_model(); do_tick(); adv(); check_all("R4");

    // R5 unhalted user write is overwritten by next refresh
    wr(4'hA, 8'h33);
    rchk("R5", 4'hA, 8'h33);
    do_tick(); adv(); check_all("R5");

    // R6 freeze
    wr(4'h8, 8'h40);
    rchk("R6", 4'h8, 8'h40);
    snap = bcd(se);
    for (int i = 0; i < 3; i++) begin do_tick(); adv(); end
    rchk("R6", 4'h9, snap);
    wr(4'h8, 8'h00);
    rchk("R6", 4'h9, snap);
    do_tick(); adv(); check_all("R6");

    // R7 set and load
    wr(4'h8, 8'h80);
    cen = 19; yr = 98; mo = 12; dt = 31; dw = 3; hr = 23; mi = 59; se = 58;
    wr(4'h9, bcd(se)); wr(4'hA, bcd(mi)); wr(4'hB, bcd(hr)); wr(4'hC, bcd(dw));
    wr(4'hD, bcd(dt)); wr(4'hE, bcd(mo)); wr(4'hF, bcd(yr)); wr(4'h1, bcd(cen));
    do_tick(); do_tick();
    check_all("R7");
    rchk("R7", 4'h8, 8'h80);
    wr(4'h8, 8'h00);
    check_all("R7");
    do_tick(); adv(); check_all("R7");
    do_tick(); adv(); check_all("R7");

    // R8 halt written in the tick cycle
    @(negedge clk); tick = 1'b1; we = 1'b1; addr = {HI, 4'h8}; wdata = 8'h40;
    @(negedge clk); tick = 1'b0; we = 1'b0;
    @(negedge clk);
    adv(); check_all("R8");
    rchk("R8", 4'h8, 8'h40);
    snap = bcd(se);
    do_tick(); adv();
    rchk("R8", 4'h9, snap);
    wr(4'h8, 8'h00);
    do_tick(); adv(); check_all("R8");

    // R9 stop without set bit
    wr(4'h9, {1'b1, bcd(se)[6:0]}); stopped = 1;
    rchk("R9", 4'h8, 8'h00);
    for (int i = 0; i < 3; i++) do_tick();
    check_all("R9");
    wr(4'h9, bcd(se)); stopped = 0;
    do_tick(); adv(); check_all("R9");

    // R11 reserved bits
    wr(4'h8, 8'hFF);
    for (int o = 1; o < 16; o++) if (o != 8) wr(4'(o), 8'hFF);
    rchk("R11", 4'h8, 8'hC0);
    rchk("R11", 4'h9, 8'hFF);
    rchk("R11", 4'hA, 8'h7F);
    rchk("R11", 4'hB, 8'h3F);
    rchk("R11", 4'hC, 8'h07);
    rchk("R11", 4'hD, 8'h3F);
    rchk("R11", 4'hE, 8'h1F);
    rchk("R11", 4'hF, 8'hFF);
    rchk("R11", 4'h1, 8'hFF);
    rchk("R11", 4'h3, 8'h00);
    cen = 20; yr = 24; mo = 2; dt = 28; dw = 4; hr = 23; mi = 59; se = 59;
    load_model(); do_tick(); adv(); check_all("R11");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule